// File: doc/BRIEF.md
# Lockable Reset Watchdog Timer

This block is a watchdog counter that sits behind a small register port. It pulses a system reset when software stops servicing it. Writes to the count and control registers are refused until software writes a 16-bit unlock word to a lock register. Any other value written there closes the lock again. The timeout is a 32-bit count made of two 16-bit halves. A control write with the run bit set loads the counter from those halves. The counter then steps down once per slow tick, a one-cycle strobe derived from a 32768 Hz source.

When the count runs out and the reset-enable bit is set, the block drives a fixed-length reset pulse and stops. When reset-enable is clear, the block sets a sticky expired flag instead, reloads the counter and keeps running. Software clears the flag by writing a one to it.

Two gating inputs come from the chip's enable registers. The interface enable blocks every register access while it is low. The count enable freezes the counter while it is low.

Top module: `lrwd_top`

## Requirements
- R1: After reset the lock is closed (the lock register reads 1 in bit 0), both load halves, the control word and the expired flag read 0, and `sys_rst_o` is low.
- R2: A write of 0xE551 to the lock register at byte offset 0xA0 opens the lock, so that it reads 0. A write of any other value to that offset closes the lock, so that it reads 1.
- R3: While the lock is closed, writes to the load-low, load-high and control registers leave their contents unchanged.
- R4: While `blk_en` is low, every write is ignored, including writes to the lock register, and `rdata` is 0.
- R5: The control word at offset 0x88 has run in bit 1, reset-enable in bit 3 and the expired flag in bit 4. An accepted control write with bit 1 set loads the counter with {load-high at 0x84, load-low at 0x80}. While run is set, the counter drops by one on each cycle in which `tick` and `cnt_en` are both high. While `cnt_en` is low, the counter holds.
- R6: The counter expires on the tick that brings it to zero, which is the tick numbered by the loaded value. If reset-enable is set at expiry, `sys_rst_o` is high for exactly RST_CYCLES (4) clocks, starting one clock after the expiring tick, and run is cleared.
- R7: If reset-enable is clear at expiry, no reset pulse is produced. Instead, the expired flag (control bit 4 and `expired_o`) is set, the counter reloads from the load value, and run stays set.
- R8: A control write with bit 4 set clears the expired flag. An expiry that falls in the same cycle as a control write is suppressed.
- R9: A load value of 0 or 1 expires on the first tick after the counter is loaded.
- R10: The registers live at byte offsets 0x80, 0x84, 0x88 and 0xA0. Any other offset reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_en | input | 1 | Interface enable; while low, no register access takes effect |
| cnt_en | input | 1 | Working-clock enable for the counter |
| tick | input | 1 | One-cycle strobe at the slow tick rate |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| sys_rst_o | output | 1 | System reset pulse |
| expired_o | output | 1 | Sticky expiry flag |

## Verification
A register write takes effect on the clock edge that samples it. `rdata` follows the register state and `addr` combinationally, so a readback is valid in the cycle after that edge. An expiring tick sets `expired_o`, or raises `sys_rst_o`, on the very next edge. The reset pulse then holds for four edges.

The bench drives its inputs on the falling edge. A behavioural model takes one step at each rising edge. Two time units after that edge, the model is compared against `rdata`, `sys_rst_o` and `expired_o`. Directed checks read registers back at the falling edge. They count reset-pulse width in falling-edge samples, and they bound latencies with cycle-limited waits.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int PKG_AW = 8;
    localparam int PKG_DW = 16;

    // Register byte offsets
    localparam logic [PKG_AW-1:0] OFF_LOAD_LO = 8'h80;
    localparam logic [PKG_AW-1:0] OFF_LOAD_HI = 8'h84;
    localparam logic [PKG_AW-1:0] OFF_CTRL    = 8'h88;
    localparam logic [PKG_AW-1:0] OFF_LOCK    = 8'hA0;

    localparam logic [PKG_DW-1:0] UNLOCK_WORD = 16'hE551;

    // Control word bit positions
    localparam int RUN_BIT = 1;
    localparam int REN_BIT = 3;
    localparam int EXP_BIT = 4;

    typedef struct packed {
        logic expired;
        logic ren;
        logic run;
    } ctrl_t;

    function automatic logic [PKG_DW-1:0] ctrl_to_word(ctrl_t c);
        logic [PKG_DW-1:0] w;
        w          = '0;
        w[RUN_BIT] = c.run;
        w[REN_BIT] = c.ren;
        w[EXP_BIT] = c.expired;
        return w;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int AW = PKG_AW,
    parameter int DW = PKG_DW,
    localparam int LW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          blk_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          expire,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] load_val,
    output ctrl_t         ctrl_o,
    output logic          ctrl_wr,
    output logic          reload,
    output logic          fire
);

    logic          locked_q;
    logic [DW-1:0] lo_q, hi_q;
    ctrl_t         ctrl_q;
    logic          acc, open_wr;

    assign acc      = wr_en && blk_en;
    assign open_wr  = acc && !locked_q;
    assign ctrl_wr  = open_wr && (addr == AW'(OFF_CTRL));
    assign reload   = ctrl_wr && wdata[RUN_BIT];
    assign fire     = expire && ctrl_q.ren;
    assign load_val = {hi_q, lo_q};
    assign ctrl_o   = ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b1;
            lo_q     <= '0;
            hi_q     <= '0;
            ctrl_q   <= '0;
        end else begin
            if (acc && addr == AW'(OFF_LOCK))
                locked_q <= (wdata != DW'(UNLOCK_WORD));
            if (open_wr && addr == AW'(OFF_LOAD_LO))
                lo_q <= wdata;
            if (open_wr && addr == AW'(OFF_LOAD_HI))
                hi_q <= wdata;
            if (ctrl_wr) begin
                ctrl_q.run <= wdata[RUN_BIT];
                ctrl_q.ren <= wdata[REN_BIT];
                if (wdata[EXP_BIT])
                    ctrl_q.expired <= 1'b0;
            end else if (expire) begin
                if (ctrl_q.ren)
                    ctrl_q.run <= 1'b0;
                else
                    ctrl_q.expired <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (blk_en) begin
            case (addr)
                AW'(OFF_LOAD_LO): rdata = lo_q;
                AW'(OFF_LOAD_HI): rdata = hi_q;
                AW'(OFF_CTRL):    rdata = ctrl_to_word(ctrl_q);
                AW'(OFF_LOCK):    rdata = DW'(locked_q);
                default:          rdata = '0;
            endcase
        end
    end

    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && blk_en && locked_q && addr == AW'(OFF_LOAD_LO)) |=> $stable(lo_q));

    assert_disabled_lock_R4: assert property (@(posedge clk) disable iff (rst)
        !blk_en |=> $stable(locked_q));

    assert_expire_stop_R6: assert property (@(posedge clk) disable iff (rst)
        fire |=> !ctrl_q.run);

    assert_expire_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (expire && !ctrl_q.ren) |=> ctrl_q.expired);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int LW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reload,
    input  logic          hold,
    input  logic [LW-1:0] load_val,
    input  logic          run,
    input  logic          cnt_en,
    input  logic          tick,
    output logic          expire
);

    logic [LW-1:0] cnt_q;
    logic          step;

    assign step   = run && cnt_en && tick && !hold;
    assign expire = step && (cnt_q <= LW'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (reload)
            cnt_q <= load_val;
        else if (expire)
            cnt_q <= load_val;
        else if (step)
            cnt_q <= cnt_q - LW'(1);
    end

    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        reload |=> (cnt_q == $past(load_val)));

    assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !reload) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int RST_CYCLES = 4,
    localparam int PW = $clog2(RST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic rst_o
);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (fire)
            left_q <= PW'(RST_CYCLES);
        else if (left_q != '0)
            left_q <= left_q - PW'(1);
    end

    assign rst_o = (left_q != '0);

    assert_fire_rst_R6: assert property (@(posedge clk) disable iff (rst)
        fire |=> rst_o);

endmodule

// File: rtl/lrwd_top.sv
module lrwd_top
    import wdt_pkg::*;
#(
    parameter int AW         = PKG_AW,
    parameter int DW         = PKG_DW,
    parameter int RST_CYCLES = 4,
    localparam int LW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          blk_en,
    input  logic          cnt_en,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          sys_rst_o,
    output logic          expired_o
);

    logic [LW-1:0] load_val;
    ctrl_t         ctrl;
    logic          ctrl_wr, reload, fire, expire;

    wdt_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .blk_en(blk_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .expire(expire), .rdata(rdata),
        .load_val(load_val), .ctrl_o(ctrl), .ctrl_wr(ctrl_wr),
        .reload(reload), .fire(fire)
    );

    wdt_counter #(.LW(LW)) u_cnt (
        .clk(clk), .rst(rst), .reload(reload), .hold(ctrl_wr),
        .load_val(load_val), .run(ctrl.run), .cnt_en(cnt_en),
        .tick(tick), .expire(expire)
    );

    wdt_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk(clk), .rst(rst), .fire(fire), .rst_o(sys_rst_o)
    );

    assign expired_o = ctrl.expired;

endmodule

// File: tb/tb_lrwd_top.sv
module tb_lrwd_top;

    localparam int CLK_PERIOD = 10;
    localparam int NRST = 4;

    logic        clk = 0, rst = 1, blk_en = 1, cnt_en = 1, tick = 0, wr_en = 0;
    logic [7:0]  addr = 8'h80;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic        sys_rst_o, expired_o;

    int errors = 0, checks = 0, cycles = 0, tcnt = 0;
    bit rst_seen = 0;

    // reference model state
    bit m_locked, m_run, m_ren, m_exp;
    int unsigned m_lo, m_hi, m_cnt, m_left;

    lrwd_top dut (
        .clk(clk), .rst(rst), .blk_en(blk_en), .cnt_en(cnt_en), .tick(tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .sys_rst_o(sys_rst_o), .expired_o(expired_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_read(input logic [7:0] a);
        if (!blk_en) return 0;
        case (a)
            8'h80: return int'(m_lo);
            8'h84: return int'(m_hi);
            8'h88: return (m_run ? 2 : 0) + (m_ren ? 8 : 0) + (m_exp ? 16 : 0);
            8'hA0: return m_locked ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    // tick strobe every third cycle
    always @(negedge clk) begin
        tcnt = (tcnt + 1) % 3;
        tick = (tcnt == 0);
    end

    // model step and per-clock comparison
    always @(posedge clk) begin
        bit acc, cw, stepping, ex;
        int unsigned ld;
        cycles++;
        if (rst) begin
            m_locked = 1; m_run = 0; m_ren = 0; m_exp = 0;
            m_lo = 0; m_hi = 0; m_cnt = 0; m_left = 0;
        end else begin
            acc = wr_en && blk_en;
            cw = acc && !m_locked && addr == 8'h88;
            ld = (m_hi << 16) | m_lo;
            stepping = m_run && cnt_en && tick && !cw;
            ex = stepping && m_cnt <= 1;
            if (cw && wdata[1]) m_cnt = ld;
            else if (ex) m_cnt = ld;
            else if (stepping) m_cnt = m_cnt - 1;
            if (ex && m_ren) m_left = NRST;
            else if (m_left > 0) m_left = m_left - 1;
            if (cw) begin
                m_run = wdata[1]; m_ren = wdata[3];
                if (wdata[4]) m_exp = 0;
            end else if (ex) begin
                if (m_ren) m_run = 0; else m_exp = 1;
            end
            if (acc && !m_locked && addr == 8'h80) m_lo = wdata;
            if (acc && !m_locked && addr == 8'h84) m_hi = wdata;
            if (acc && addr == 8'hA0) m_locked = (wdata != 16'hE551);
        end
        #2;
        if (!rst) begin
            chk("R6 model sys_rst_o", sys_rst_o, m_left > 0);
            chk("R7 model expired_o", expired_o, m_exp);
            chk("R2 R3 R5 model rdata", rdata, model_read(addr));
            if (sys_rst_o) rst_seen = 1;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(8'hA0, 1, "R1 lock after reset");
        rd(8'h88, 0, "R1 ctrl after reset");
        rd(8'h80, 0, "R1 load low after reset");
        chk("R1 sys_rst_o after reset", sys_rst_o, 0);
        chk("R1 expired_o after reset", expired_o, 0);
        // R3 locked write ignored
        wr(8'h80, 16'h0005);
        rd(8'h80, 0, "R3 load low write while locked");
        // R4 disabled interface
        @(negedge clk); blk_en = 0;
        wr(8'hA0, 16'hE551);
        #1 chk("R4 rdata while disabled", rdata, 0);
        @(negedge clk); blk_en = 1;
        rd(8'hA0, 1, "R4 lock unchanged after disabled write");
        // R2 unlock and R10 offsets
        wr(8'hA0, 16'hE551);
        rd(8'hA0, 0, "R2 unlocked");
        wr(8'h80, 16'h0005);
        wr(8'h84, 16'h0001);
        rd(8'h84, 1, "R10 load high offset");
        wr(8'h84, 16'h0000);
        rd(8'h80, 5, "R10 load low offset");
        wr(8'h90, 16'hFFFF);
        rd(8'h90, 0, "R10 unmapped offset");
        // R2 relock with wrong value, R3 ctrl ignored
        wr(8'hA0, 16'h1234);
        rd(8'hA0, 1, "R2 relocked");
        wr(8'h88, 16'h000A);
        rd(8'h88, 0, "R3 ctrl write while locked");
        wr(8'hA0, 16'hE551);
        // R6 reset on expiry
        wr(8'h88, 16'h000A);
        n = 0;
        while (!sys_rst_o && n < 40) begin @(negedge clk); n++; end
        chk("R6 reset pulse seen", sys_rst_o, 1);
        n = 0;
        while (sys_rst_o && n < 10) begin @(negedge clk); n++; end
        chk("R6 reset pulse width", n, NRST);
        rd(8'h88, 8, "R6 run cleared");
        // R5 freeze, R7 expiry without reset
        @(negedge clk); cnt_en = 0;
        wr(8'h88, 16'h0002);
        repeat (30) @(negedge clk);
        chk("R5 frozen counter no expiry", expired_o, 0);
        rst_seen = 0;
        cnt_en = 1;
        n = 0;
        while (!expired_o && n < 40) begin @(negedge clk); n++; end
        chk("R7 expired flag set", expired_o, 1);
        chk("R7 no reset pulse", rst_seen, 0);
        rd(8'h88, 16'h0012, "R7 ctrl keeps run with flag");
        // R8 clear flag
        wr(8'h88, 16'h0010);
        rd(8'h88, 0, "R8 flag cleared");
        chk("R8 expired_o cleared", expired_o, 0);
        // R9 load of 1 and of 0
        for (int v = 1; v >= 0; v--) begin
            wr(8'h80, 16'(v));
            wr(8'h88, 16'h000A);
            n = 0;
            while (!sys_rst_o && n < 5) begin @(negedge clk); n++; end
            chk($sformatf("R9 first tick expiry load=%0d", v), sys_rst_o, 1);
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule